// File: doc/BRIEF.md
# Row-Hit-First DRAM Burst Picker

This block picks the next burst to service from a small pending queue of DRAM requests. Each queue slot carries a rank, a bank, a row, a read/write flag and a valid bit, and a lower slot index means an older request. For every bank the block is given its open/closed state, the open row, the earliest cycles at which a read or write column command, an activate and a precharge may go out. For every rank it is told whether the rank is free of refresh activity. It also receives the current cycle and the first cycle at which a column command could use the data bus ("bus-ready time").

A start pulse launches one evaluation. One cycle later the block presents a done pulse, a found flag, the slot index of the winner and the column cycle at which the winner could issue. The policy is row hits first and oldest first. A row hit that can use the bus with no gap wins outright. Failing that, a miss whose activate fits in the shadow of current bus traffic is preferred over a ready but gapped row hit, and a plain miss is used only when no row hit is waiting.

Top module: `rowhit_picker`

## Requirements
- R1: After reset, pick_done, pick_found, pick_idx and pick_col_at are all zero.
- R2: pick_done is high for exactly the one cycle after a cycle with start high. The found flag, index and column time change only in that cycle and hold their values otherwise.
- R3: A slot is eligible only when its valid bit is set and the bit of its rank in rank_idle is 1. When no slot is eligible, pick_found is 0 with pick_idx and pick_col_at both 0.
- R4: A row hit is an eligible slot whose bank is open with a matching row. Its column time is the bank's read time when the slot's read flag is 1 and the bank's write time otherwise. The oldest hit with column time at or before bus_ready wins, even over older hits that are not seamless.
- R5: With no seamless hit and no hidden miss, the oldest row hit wins, reporting its own column time.
- R6: A waiting bank (any eligible slot targets it) has an activate time equal to its allowed-activate time when closed, or max(allowed-precharge, now) + T_RP when open. Its candidate column time is max(column limit, activate + T_RCD). The column limit is the read or write time per the oldest eligible slot on that bank.
- R7: The miss bank set is the waiting banks whose candidate column time is at or before bus_ready. When there are none, it is the waiting banks sharing the smallest activate time. A miss winner is the oldest eligible non-hit slot in that set, reporting its bank's candidate column time.
- R8: An activate is hidden when the smallest activate time in the bank set is at or before max(bus_ready - T_RCD, now). A hidden miss beats any non-seamless row hit.
- R9: A miss that is not hidden is picked only when no row hit is eligible.
- R10: bus_ready - T_RCD saturates at zero, so with bus_ready below T_RCD the hidden limit is now.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one evaluation |
| now | input | 32 | Current cycle |
| bus_ready | input | 32 | Earliest cycle a column command can use the bus |
| ent_valid | input | N_ENT | Slot valid bits, slot 0 oldest |
| ent_rank | input | N_ENT*RANK_W | Slot rank fields |
| ent_bank | input | N_ENT*BANK_W | Slot bank-in-rank fields |
| ent_row | input | N_ENT*ROW_W | Slot row fields |
| ent_read | input | N_ENT | Slot read flag (1 read, 0 write) |
| rank_idle | input | N_RANK | 1 when the rank has no refresh activity |
| bank_open | input | NB | Bank has a row open (bank id = rank*N_BANK+bank) |
| bank_row | input | NB*ROW_W | Open row per bank |
| bank_rd_at | input | NB*32 | Earliest read column cycle per bank |
| bank_wr_at | input | NB*32 | Earliest write column cycle per bank |
| bank_act_at | input | NB*32 | Earliest activate cycle per bank |
| bank_pre_at | input | NB*32 | Earliest precharge cycle per bank |
| pick_done | output | 1 | One-cycle result strobe |
| pick_found | output | 1 | A slot was chosen |
| pick_idx | output | IDX_W | Chosen slot index |
| pick_col_at | output | 32 | Column cycle of the chosen slot |

## Verification
The interesting overlap is a non-seamless row hit and a miss bank competing in the same evaluation. The outcome then turns on the hidden-activate test against bus_ready - T_RCD and the current cycle. The bench builds this by placing a hit and a closed-bank miss together, then moving the miss bank's activate time one cycle either side of the hidden limit, including a bus_ready below T_RCD. The winning index and column time must flip exactly at that boundary. A second overlap sets a seamless miss bank against an earlier-activating bank; the seamless one must win.

// File: rtl/pick_pkg.sv
package pick_pkg;
    localparam int CYC_W = 32;
    typedef logic [CYC_W-1:0] cyc_t;

    function automatic cyc_t cyc_max(input cyc_t a, input cyc_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic cyc_t cyc_sat_sub(input cyc_t a, input cyc_t b);
        return (a > b) ? (a - b) : '0;
    endfunction
endpackage

// File: rtl/pick_first.sv
module pick_first #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/pick_entry_eval.sv
module pick_entry_eval
    import pick_pkg::*;
#(
    parameter int N_RANK = 2,
    parameter int N_BANK = 4,
    parameter int ROW_W  = 14,
    parameter int RANK_W = 1,
    parameter int BANK_W = 2,
    parameter int GID_W  = 3,
    localparam int NB    = N_RANK * N_BANK
) (
    input  logic              valid,
    input  logic [RANK_W-1:0] rank,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic              is_read,
    input  logic [N_RANK-1:0] rank_idle,
    input  logic [NB-1:0]     bank_open,
    input  logic [NB*ROW_W-1:0] bank_row,
    input  logic [NB*CYC_W-1:0] bank_rd_at,
    input  logic [NB*CYC_W-1:0] bank_wr_at,
    output logic              elig,
    output logic              hit,
    output logic [GID_W-1:0]  gid,
    output cyc_t              col_at
);
    int gid_int;

    always_comb begin
        gid_int = int'(rank) * N_BANK + int'(bank);
        gid     = GID_W'(gid_int);
        elig    = valid && rank_idle[rank];
        hit     = elig && bank_open[gid] && (bank_row[gid*ROW_W +: ROW_W] == row);
        col_at  = is_read ? bank_rd_at[gid*CYC_W +: CYC_W]
                          : bank_wr_at[gid*CYC_W +: CYC_W];
    end
endmodule

// File: rtl/pick_bank_prep.sv
module pick_bank_prep
    import pick_pkg::*;
#(
    parameter int NB    = 8,
    parameter int T_RCD = 14,
    parameter int T_RP  = 14
) (
    input  cyc_t              now,
    input  cyc_t              bus_ready,
    input  logic [NB-1:0]     waiting,
    input  logic [NB-1:0]     dir_rd,
    input  logic [NB-1:0]     bank_open,
    input  logic [NB*CYC_W-1:0] bank_rd_at,
    input  logic [NB*CYC_W-1:0] bank_wr_at,
    input  logic [NB*CYC_W-1:0] bank_act_at,
    input  logic [NB*CYC_W-1:0] bank_pre_at,
    output logic [NB-1:0]     mask,
    output logic              hidden,
    output logic [NB*CYC_W-1:0] cand_col
);
    localparam cyc_t RCD = cyc_t'(T_RCD);
    localparam cyc_t RP  = cyc_t'(T_RP);

    cyc_t          act_t [NB];
    logic [NB-1:0] seam_b;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        cyc_t col_lim;
        assign act_t[g] = bank_open[g]
                        ? cyc_max(bank_pre_at[g*CYC_W +: CYC_W], now) + RP
                        : bank_act_at[g*CYC_W +: CYC_W];
        assign col_lim  = dir_rd[g] ? bank_rd_at[g*CYC_W +: CYC_W]
                                    : bank_wr_at[g*CYC_W +: CYC_W];
        assign cand_col[g*CYC_W +: CYC_W] = cyc_max(col_lim, act_t[g] + RCD);
        assign seam_b[g] = waiting[g] && (cand_col[g*CYC_W +: CYC_W] <= bus_ready);
    end

    cyc_t min_all;
    cyc_t min_seam;
    cyc_t hide_lim;

    always_comb begin
        min_all  = '1;
        min_seam = '1;
        for (int g = 0; g < NB; g++) begin
            if (waiting[g] && act_t[g] < min_all)  min_all  = act_t[g];
            if (seam_b[g]  && act_t[g] < min_seam) min_seam = act_t[g];
        end
        for (int g = 0; g < NB; g++) begin
            mask[g] = (|seam_b) ? seam_b[g] : (waiting[g] && act_t[g] == min_all);
        end
        hide_lim = cyc_max(cyc_sat_sub(bus_ready, RCD), now);
        hidden   = (|waiting) && (((|seam_b) ? min_seam : min_all) <= hide_lim);
    end
endmodule

// File: rtl/rowhit_picker.sv
module rowhit_picker
    import pick_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int N_RANK = 2,
    parameter int N_BANK = 4,
    parameter int ROW_W  = 14,
    parameter int T_RCD  = 14,
    parameter int T_RP   = 14,
    localparam int NB     = N_RANK * N_BANK,
    localparam int IDX_W  = $clog2(N_ENT),
    localparam int RANK_W = (N_RANK > 1) ? $clog2(N_RANK) : 1,
    localparam int BANK_W = (N_BANK > 1) ? $clog2(N_BANK) : 1,
    localparam int GID_W  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [31:0]             now,
    input  logic [31:0]             bus_ready,
    input  logic [N_ENT-1:0]        ent_valid,
    input  logic [N_ENT*RANK_W-1:0] ent_rank,
    input  logic [N_ENT*BANK_W-1:0] ent_bank,
    input  logic [N_ENT*ROW_W-1:0]  ent_row,
    input  logic [N_ENT-1:0]        ent_read,
    input  logic [N_RANK-1:0]       rank_idle,
    input  logic [NB-1:0]           bank_open,
    input  logic [NB*ROW_W-1:0]     bank_row,
    input  logic [NB*32-1:0]        bank_rd_at,
    input  logic [NB*32-1:0]        bank_wr_at,
    input  logic [NB*32-1:0]        bank_act_at,
    input  logic [NB*32-1:0]        bank_pre_at,
    output logic                    pick_done,
    output logic                    pick_found,
    output logic [IDX_W-1:0]        pick_idx,
    output logic [31:0]             pick_col_at
);
    typedef struct packed {
        logic             done;
        logic             found;
        logic [IDX_W-1:0] idx;
        cyc_t             col;
    } pick_st_t;

    pick_st_t st_d, st_q;

    logic [N_ENT-1:0] elig, hit, seam_hit, miss_in_set;
    logic [GID_W-1:0] gid   [N_ENT];
    cyc_t             e_col [N_ENT];

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        pick_entry_eval #(
            .N_RANK(N_RANK), .N_BANK(N_BANK), .ROW_W(ROW_W),
            .RANK_W(RANK_W), .BANK_W(BANK_W), .GID_W(GID_W)
        ) eval_i (
            .valid     (ent_valid[i]),
            .rank      (ent_rank[i*RANK_W +: RANK_W]),
            .bank      (ent_bank[i*BANK_W +: BANK_W]),
            .row       (ent_row[i*ROW_W +: ROW_W]),
            .is_read   (ent_read[i]),
            .rank_idle (rank_idle),
            .bank_open (bank_open),
            .bank_row  (bank_row),
            .bank_rd_at(bank_rd_at),
            .bank_wr_at(bank_wr_at),
            .elig      (elig[i]),
            .hit       (hit[i]),
            .gid       (gid[i]),
            .col_at    (e_col[i])
        );
        assign seam_hit[i] = hit[i] && (e_col[i] <= bus_ready);
    end

    logic [NB-1:0] waiting, dir_rd, bmask;
    logic          hidden;
    logic [NB*CYC_W-1:0] cand_col;

    // Oldest eligible slot on each bank sets that bank's column direction.
    always_comb begin
        waiting = '0;
        dir_rd  = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (elig[i]) begin
                waiting[gid[i]] = 1'b1;
                dir_rd[gid[i]]  = ent_read[i];
            end
        end
    end

    pick_bank_prep #(.NB(NB), .T_RCD(T_RCD), .T_RP(T_RP)) prep_i (
        .now        (now),
        .bus_ready  (bus_ready),
        .waiting    (waiting),
        .dir_rd     (dir_rd),
        .bank_open  (bank_open),
        .bank_rd_at (bank_rd_at),
        .bank_wr_at (bank_wr_at),
        .bank_act_at(bank_act_at),
        .bank_pre_at(bank_pre_at),
        .mask       (bmask),
        .hidden     (hidden),
        .cand_col   (cand_col)
    );

    for (genvar i = 0; i < N_ENT; i++) begin : g_miss
        assign miss_in_set[i] = elig[i] && !hit[i] && bmask[gid[i]];
    end

    logic             any_seam, any_hit, any_miss;
    logic [IDX_W-1:0] idx_seam, idx_hit, idx_miss;

    pick_first #(.N(N_ENT), .W(IDX_W)) first_seam_i (.req(seam_hit),    .any(any_seam), .idx(idx_seam));
    pick_first #(.N(N_ENT), .W(IDX_W)) first_hit_i  (.req(hit),         .any(any_hit),  .idx(idx_hit));
    pick_first #(.N(N_ENT), .W(IDX_W)) first_miss_i (.req(miss_in_set), .any(any_miss), .idx(idx_miss));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.done = 1'b1;
            if (any_seam) begin
                st_d.found = 1'b1;
                st_d.idx   = idx_seam;
                st_d.col   = e_col[idx_seam];
            end else if (any_miss && hidden) begin
                st_d.found = 1'b1;
                st_d.idx   = idx_miss;
                st_d.col   = cand_col[gid[idx_miss]*CYC_W +: CYC_W];
            end else if (any_hit) begin
                st_d.found = 1'b1;
                st_d.idx   = idx_hit;
                st_d.col   = e_col[idx_hit];
            end else if (any_miss) begin
                st_d.found = 1'b1;
                st_d.idx   = idx_miss;
                st_d.col   = cand_col[gid[idx_miss]*CYC_W +: CYC_W];
            end else begin
                st_d.found = 1'b0;
                st_d.idx   = '0;
                st_d.col   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pick_done   = st_q.done;
    assign pick_found  = st_q.found;
    assign pick_idx    = st_q.idx;
    assign pick_col_at = st_q.col;
endmodule

// File: rtl/rowhit_picker_chk.sv
module rowhit_picker_chk #(
    parameter int N_ENT = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [N_ENT-1:0] ent_valid,
    input logic             pick_done,
    input logic             pick_found,
    input logic [IDX_W-1:0] pick_idx,
    input logic [31:0]      pick_col_at
);
    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pick_done);                                                     // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !pick_done);                                                   // R2
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(pick_found) && $stable(pick_idx) && $stable(pick_col_at))); // R2
    AST_EMPTY_QUEUE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ent_valid == '0) |=> (!pick_found && pick_idx == '0 && pick_col_at == '0)); // R3
    AST_WINNER_WAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!pick_found || (|(($past(ent_valid) >> pick_idx) & N_ENT'(1))))); // R3
endmodule

bind rowhit_picker rowhit_picker_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ent_valid  (ent_valid),
    .pick_done  (pick_done),
    .pick_found (pick_found),
    .pick_idx   (pick_idx),
    .pick_col_at(pick_col_at)
);

// File: tb/rowhit_picker_tb_top.sv
`timescale 1ns/1ps
module rowhit_picker_tb_top;
    localparam int N_ENT = 8;
    localparam int N_RANK = 2;
    localparam int N_BANK = 4;
    localparam int NB = 8;
    localparam int ROW_W = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] now, bus_ready;
    logic [N_ENT-1:0] ent_valid, ent_read;
    logic [N_ENT-1:0] ent_rank;
    logic [N_ENT*2-1:0] ent_bank;
    logic [N_ENT*ROW_W-1:0] ent_row;
    logic [N_RANK-1:0] rank_idle;
    logic [NB-1:0] bank_open;
    logic [NB*ROW_W-1:0] bank_row;
    logic [NB*32-1:0] bank_rd_at, bank_wr_at, bank_act_at, bank_pre_at;
    logic pick_done, pick_found;
    logic [2:0] pick_idx;
    logic [31:0] pick_col_at;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rowhit_picker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .now(now), .bus_ready(bus_ready),
        .ent_valid(ent_valid), .ent_rank(ent_rank), .ent_bank(ent_bank), .ent_row(ent_row),
        .ent_read(ent_read), .rank_idle(rank_idle), .bank_open(bank_open), .bank_row(bank_row),
        .bank_rd_at(bank_rd_at), .bank_wr_at(bank_wr_at), .bank_act_at(bank_act_at),
        .bank_pre_at(bank_pre_at), .pick_done(pick_done), .pick_found(pick_found),
        .pick_idx(pick_idx), .pick_col_at(pick_col_at)
    );

    typedef struct packed {
        logic [7:0]  valid;
        logic [7:0]  hit;
        logic [31:0] br;
        logic        found;
        logic [2:0]  idx;
        logic [31:0] col;
    } vec_t;

    // Slot i -> rank i/4, bank i%4; banks open on row 5, read time 80-10*g, precharge 1000.
    localparam vec_t VECS [8] = '{
        '{8'hFF, 8'hFF, 32'd35, 1'b1, 3'd5, 32'd30},   // R4 later seamless hit beats older hits
        '{8'h7F, 8'h7F, 32'd35, 1'b1, 3'd5, 32'd30},   // R4
        '{8'hFF, 8'h0F, 32'd5,  1'b1, 3'd0, 32'd80},   // R5 oldest prepared hit
        '{8'hFF, 8'h00, 32'd5,  1'b1, 3'd0, 32'd1028}, // R9 misses only
        '{8'h00, 8'h00, 32'd35, 1'b0, 3'd0, 32'd0},    // R3 empty
        '{8'hF0, 8'h0F, 32'd5,  1'b1, 3'd4, 32'd1028}, // R7 miss winner, oldest in set
        '{8'hFF, 8'h30, 32'd55, 1'b1, 3'd4, 32'd40},   // R4
        '{8'h0C, 8'h08, 32'd65, 1'b1, 3'd3, 32'd50}    // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_bank(input int g, input logic op, input logic [31:0] rd,
                            input logic [31:0] wr, input logic [31:0] act, input logic [31:0] pre);
        bank_open[g] = op;
        bank_row[g*ROW_W +: ROW_W] = 14'd5;
        bank_rd_at[g*32 +: 32] = rd;
        bank_wr_at[g*32 +: 32] = wr;
        bank_act_at[g*32 +: 32] = act;
        bank_pre_at[g*32 +: 32] = pre;
    endtask

    task automatic setup(input logic [7:0] valid, input logic [7:0] hitm, input logic [31:0] br);
        now = 0;
        bus_ready = br;
        rank_idle = '1;
        ent_valid = valid;
        ent_read = '1;
        for (int i = 0; i < N_ENT; i++) begin
            ent_rank[i] = (i >= 4);
            ent_bank[i*2 +: 2] = 2'(i % 4);
            ent_row[i*ROW_W +: ROW_W] = hitm[i] ? 14'd5 : 14'd9;
        end
        for (int g = 0; g < NB; g++)
            set_bank(g, 1'b1, 32'(80 - 10*g), 32'(80 - 10*g), 32'd0, 32'd1000);
    endtask

    task automatic run_pick(input string req, input logic f, input logic [2:0] idx, input logic [31:0] col);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(req, 32'(pick_done), 32'd1);
        check(req, 32'(pick_found), 32'(f));
        check(req, 32'(pick_idx), 32'(idx));
        check(req, pick_col_at, col);
        @(negedge clk);
        check("R2", 32'(pick_done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        setup(8'h00, 8'h00, 32'd0);
        repeat (3) @(negedge clk);
        check("R1", 32'(pick_done), 32'd0);
        check("R1", 32'(pick_found), 32'd0);
        check("R1", 32'(pick_idx), 32'd0);
        check("R1", pick_col_at, 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < 8; v++) begin
            setup(VECS[v].valid, VECS[v].hit, VECS[v].br);
            run_pick("R4/R5/R7/R9 table", VECS[v].found, VECS[v].idx, VECS[v].col);
        end

        // R3: rank 0 refreshing, its seamless hits are skipped
        setup(8'hFF, 8'hFF, 32'd75);
        rank_idle = 2'b10;
        run_pick("R3", 1'b1, 3'd4, 32'd40);
        rank_idle = 2'b00;
        run_pick("R3", 1'b0, 3'd0, 32'd0);

        // R4: write slot uses the bank's write time
        setup(8'hFF, 8'hFF, 32'd35);
        ent_read[0] = 1'b0;
        bank_wr_at[31:0] = 32'd5;
        run_pick("R4", 1'b1, 3'd0, 32'd5);

        // R8: hidden miss beats prepared hit; R9: unhidden one loses
        setup(8'h05, 8'h04, 32'd200);
        now = 100;
        set_bank(0, 1'b0, 32'd250, 32'd250, 32'd150, 32'd1000);
        set_bank(2, 1'b1, 32'd300, 32'd300, 32'd0, 32'd1000);
        run_pick("R8", 1'b1, 3'd0, 32'd250);
        bank_act_at[31:0] = 32'd187;
        run_pick("R9", 1'b1, 3'd2, 32'd300);
        bank_act_at[31:0] = 32'd186;
        run_pick("R8", 1'b1, 3'd0, 32'd250);

        // R7: seamless miss bank beats earlier-activating bank
        setup(8'h03, 8'h00, 32'd100);
        set_bank(0, 1'b0, 32'd500, 32'd500, 32'd10, 32'd0);
        set_bank(1, 1'b0, 32'd0, 32'd0, 32'd50, 32'd0);
        run_pick("R7", 1'b1, 3'd1, 32'd64);

        // R6: open bank activates after precharge window plus T_RP
        setup(8'h01, 8'h00, 32'd0);
        now = 30;
        set_bank(0, 1'b1, 32'd0, 32'd0, 32'd0, 32'd20);
        run_pick("R6", 1'b1, 3'd0, 32'd58);
        bank_pre_at[31:0] = 32'd50;
        run_pick("R6", 1'b1, 3'd0, 32'd78);

        // R10: bus_ready below T_RCD, limit falls back to now
        setup(8'h03, 8'h02, 32'd5);
        now = 40;
        set_bank(0, 1'b0, 32'd0, 32'd0, 32'd41, 32'd1000);
        set_bank(1, 1'b1, 32'd100, 32'd100, 32'd0, 32'd1000);
        run_pick("R10", 1'b1, 3'd1, 32'd100);
        bank_act_at[31:0] = 32'd40;
        run_pick("R10", 1'b1, 3'd0, 32'd54);

        // R2: result holds while inputs change without start
        setup(8'hFF, 8'hFF, 32'd75);
        repeat (2) @(negedge clk);
        check("R2", 32'(pick_done), 32'd0);
        check("R2", 32'(pick_idx), 32'd0);
        check("R2", pick_col_at, 32'd54);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule